// File: doc/BRIEF.md
# Lane delay-shift result evaluator

This block sits beside a delay-search engine that sweeps the coarse delay of one byte lane. After a sweep the engine returns one result word per data bit, eight in all. The block takes those words one per clock over a valid/ready handshake. For each word it decides whether the search completed and whether a pass/fail edge was seen. It then moves the lane through a small state machine of search phases. Alongside, it keeps the smallest and largest pass-to-fail delay seen on the lane.

A run opens with a one-cycle start pulse, which captures three inputs: the direction (receive or transmit), which search phase is running, and the state the lane currently holds. Eight accepted beats later, a one-cycle done pulse marks that the new lane state, the chosen coarse shift and the lock flag are valid. Those outputs hold until the next start. If the lane's state does not belong to the phase being run, the lane takes no part: its words are still drawn and done still follows after eight beats.

Top module: `lane_shift_eval`

## Requirements
- R1: Word decoding: bit 25 set means the search completed for that bit. The delay is `word[4:0]` in receive mode (`mode_i`=0) and `word[5:0]` in transmit mode (`mode_i`=1); all higher bits are ignored. A delay of 31 (receive) or 0 (transmit) means no edge was found.
- R2: A completed word with an edge yields a pass-to-fail point of delay+1 (receive) or delay-1 (transmit). These points are folded into a running minimum and maximum that start every run at 31 (receive) or 63 (transmit) for the minimum and at 0 for the maximum. `shift_o` is the running maximum in receive mode and the running minimum in transmit mode; it is 0 when nothing was folded.
- R3: First phase (`phase_i`=0) applies to a lane in state 3 and starts with lock set. A word that did not complete gives state 1 and clears lock. A word with no edge gives state 4 and clears lock. After either exit the remaining words of the run are ignored. If all eight words have edges, the lane stays in state 3 and lock stays set.
- R4: Extended-extended phase (`phase_i`=1) applies to a lane in state 4. A word that did not complete, or a word with no edge, gives state 2, clears lock and skips the rest. Each good word sets lock. If all words are good, the lane stays in state 4.
- R5: Secondary phase (`phase_i`=2) applies to a lane in state 2. A word that did not complete gives state 1 and skips the rest. A completed word with no edge is neither folded nor counted. Lock is set at done only if all eight words were completed with an edge. A lane ending in state 1 never reports lock.
- R6: A lane whose state is not the one owned by the phase (state 3 for phase 0, 4 for phase 1, 2 for phase 2, none for phase 3) ignores every word. It reports its input state unchanged, shift 0 and lock 0, and done still follows its eighth beat.
- R7: `res_ready_o` is high only while a run collects words. A beat counts only when `res_valid_i` and `res_ready_o` are both high. `done_o` is high for exactly the one cycle after the eighth beat. A start pulse during a run is ignored, and outputs do not change between runs.
- R8: Synchronous reset returns the block to idle with ready, done, lane state, shift and lock all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | One-cycle pulse opening a run while idle |
| mode_i | input | 1 | 0 = receive direction, 1 = transmit direction |
| phase_i | input | 2 | 0 = first, 1 = extended-extended, 2 = secondary search |
| lane_state_i | input | 3 | Lane state before this run (0 pass, 1 fail, 2 secondary, 3 extended, 4 extended-extended) |
| res_valid_i | input | 1 | Result word valid |
| res_ready_o | output | 1 | Block accepts a result word |
| res_word_i | input | 32 | Per-bit result word from the search engine |
| lane_state_o | output | 3 | Lane state after the run |
| shift_o | output | 6 | Chosen coarse shift |
| lock_o | output | 1 | Lane locked |
| done_o | output | 1 | One-cycle pulse: results valid |

## Verification
A wrong internal state shows in three ways, and each is caught the cycle done rises. If the beat count drifts, done comes too early or too late. A skip flag that fails to latch lets later words reach the fold, so the shift changes. A missing reset of the minimum or maximum carries a value over from an earlier run of the other direction. The table holds words placed after an exit that would move the shift if they were folded, and it runs the two directions back to back. It also includes lanes that the phase does not own, and words whose high delay bit must be dropped in receive mode.

// File: rtl/lse_pkg.sv
package lse_pkg;

    // Lane state codes; neighbours decode these values.
    localparam logic [2:0] LS_PASS   = 3'd0;
    localparam logic [2:0] LS_FAIL   = 3'd1;
    localparam logic [2:0] LS_SECOND = 3'd2;
    localparam logic [2:0] LS_EXT    = 3'd3;
    localparam logic [2:0] LS_EXT2   = 3'd4;
    localparam logic [2:0] LS_NONE   = 3'd7;

    // Search phase codes.
    localparam logic [1:0] PH_FIRST  = 2'd0;
    localparam logic [1:0] PH_EXT2   = 2'd1;
    localparam logic [1:0] PH_SECOND = 2'd2;

    // State a lane must hold to take part in a phase.
    function automatic logic [2:0] phase_owner(input logic [1:0] ph);
        case (ph)
            PH_FIRST:  return LS_EXT;
            PH_EXT2:   return LS_EXT2;
            PH_SECOND: return LS_SECOND;
            default:   return LS_NONE;
        endcase
    endfunction

endpackage

// File: rtl/lse_word_decode.sv
module lse_word_decode #(
    parameter int DATA_W   = 32,
    parameter int FLAG_BIT = 25,
    parameter int DLY_W    = 6
) (
    input  logic [DATA_W-1:0] word_i,
    input  logic              tx_i,
    output logic              cmpl_o,
    output logic              no_edge_o,
    output logic [DLY_W-1:0]  point_o
);
    localparam logic [DLY_W-1:0] RX_TOP = {1'b0, {(DLY_W-1){1'b1}}};

    logic [DLY_W-1:0] masked;
    logic             unused_bits;

    always_comb begin
        masked    = tx_i ? word_i[DLY_W-1:0] : {1'b0, word_i[DLY_W-2:0]};
        cmpl_o    = word_i[FLAG_BIT];
        no_edge_o = tx_i ? (masked == '0) : (masked == RX_TOP);
        point_o   = tx_i ? masked - DLY_W'(1) : masked + DLY_W'(1);
    end

    assign unused_bits = ^{word_i[DATA_W-1:FLAG_BIT+1], word_i[FLAG_BIT-1:DLY_W]};

endmodule

// File: rtl/lse_span.sv
module lse_span #(
    parameter int DLY_W = 6
) (
    input  logic [DLY_W-1:0] cur_min_i,
    input  logic [DLY_W-1:0] cur_max_i,
    input  logic [DLY_W-1:0] point_i,
    input  logic             tx_i,
    output logic [DLY_W-1:0] new_min_o,
    output logic [DLY_W-1:0] new_max_o,
    output logic [DLY_W-1:0] pick_o
);
    always_comb begin
        new_min_o = (point_i < cur_min_i) ? point_i : cur_min_i;
        new_max_o = (point_i > cur_max_i) ? point_i : cur_max_i;
        // Receive keeps the widest pass, transmit the narrowest.
        pick_o    = tx_i ? new_min_o : new_max_o;
    end
endmodule

// File: rtl/lane_shift_eval.sv
module lane_shift_eval #(
    parameter int DATA_W   = 32,
    parameter int FLAG_BIT = 25,
    parameter int DLY_W    = 6,
    parameter int BEATS    = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              start_i,
    input  logic              mode_i,
    input  logic [1:0]        phase_i,
    input  logic [2:0]        lane_state_i,
    input  logic              res_valid_i,
    output logic              res_ready_o,
    input  logic [DATA_W-1:0] res_word_i,
    output logic [2:0]        lane_state_o,
    output logic [DLY_W-1:0]  shift_o,
    output logic              lock_o,
    output logic              done_o
);
    import lse_pkg::*;

    localparam int CNT_W = $clog2(BEATS + 1);
    localparam logic [DLY_W-1:0] RX_MIN0 = {1'b0, {(DLY_W-1){1'b1}}};
    localparam logic [DLY_W-1:0] TX_MIN0 = {DLY_W{1'b1}};

    typedef struct packed {
        logic             busy;
        logic             done;
        logic             mode;
        logic [1:0]       phase;
        logic             owned;
        logic             skip;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] ok_cnt;
        logic [2:0]       lstate;
        logic [DLY_W-1:0] dmin;
        logic [DLY_W-1:0] dmax;
        logic [DLY_W-1:0] shift;
        logic             lock;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    logic             w_cmpl, w_no_edge;
    logic [DLY_W-1:0] w_point;
    logic [DLY_W-1:0] s_min, s_max, s_pick;
    logic             fold;

    lse_word_decode #(
        .DATA_W  (DATA_W),
        .FLAG_BIT(FLAG_BIT),
        .DLY_W   (DLY_W)
    ) i_decode (
        .word_i   (res_word_i),
        .tx_i     (ctx_q.mode),
        .cmpl_o   (w_cmpl),
        .no_edge_o(w_no_edge),
        .point_o  (w_point)
    );

    lse_span #(
        .DLY_W(DLY_W)
    ) i_span (
        .cur_min_i(ctx_q.dmin),
        .cur_max_i(ctx_q.dmax),
        .point_i  (w_point),
        .tx_i     (ctx_q.mode),
        .new_min_o(s_min),
        .new_max_o(s_max),
        .pick_o   (s_pick)
    );

    always_comb begin
        ctx_d      = ctx_q;
        ctx_d.done = 1'b0;
        fold       = 1'b0;

        if (!ctx_q.busy) begin
            if (start_i) begin
                ctx_d.busy   = 1'b1;
                ctx_d.mode   = mode_i;
                ctx_d.phase  = phase_i;
                ctx_d.lstate = lane_state_i;
                ctx_d.owned  = (lane_state_i == phase_owner(phase_i));
                ctx_d.skip   = 1'b0;
                ctx_d.cnt    = '0;
                ctx_d.ok_cnt = '0;
                ctx_d.dmin   = mode_i ? TX_MIN0 : RX_MIN0;
                ctx_d.dmax   = '0;
                ctx_d.shift  = '0;
                ctx_d.lock   = (lane_state_i == LS_EXT) && (phase_i == PH_FIRST);
            end
        end else if (res_valid_i) begin
            ctx_d.cnt = ctx_q.cnt + CNT_W'(1);

            if (ctx_q.owned && !ctx_q.skip) begin
                case (ctx_q.phase)
                    PH_FIRST: begin
                        if (!w_cmpl) begin
                            ctx_d.lstate = LS_FAIL;
                            ctx_d.lock   = 1'b0;
                            ctx_d.skip   = 1'b1;
                        end else if (w_no_edge) begin
                            ctx_d.lstate = LS_EXT2;
                            ctx_d.lock   = 1'b0;
                            ctx_d.skip   = 1'b1;
                        end else begin
                            fold = 1'b1;
                        end
                    end
                    PH_EXT2: begin
                        if (!w_cmpl || w_no_edge) begin
                            ctx_d.lstate = LS_SECOND;
                            ctx_d.lock   = 1'b0;
                            ctx_d.skip   = 1'b1;
                        end else begin
                            ctx_d.lock = 1'b1;
                            fold       = 1'b1;
                        end
                    end
                    PH_SECOND: begin
                        if (!w_cmpl) begin
                            ctx_d.lstate = LS_FAIL;
                            ctx_d.skip   = 1'b1;
                        end else if (!w_no_edge) begin
                            ctx_d.ok_cnt = ctx_q.ok_cnt + CNT_W'(1);
                            fold         = 1'b1;
                        end
                    end
                    default: ;
                endcase
            end

            if (fold) begin
                ctx_d.dmin  = s_min;
                ctx_d.dmax  = s_max;
                ctx_d.shift = s_pick;
            end

            if (ctx_q.cnt == CNT_W'(BEATS - 1)) begin
                ctx_d.busy = 1'b0;
                ctx_d.done = 1'b1;
                if (ctx_q.owned && ctx_q.phase == PH_SECOND)
                    ctx_d.lock = (ctx_d.ok_cnt == CNT_W'(BEATS));
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) ctx_q <= '0;
        else       ctx_q <= ctx_d;
    end

    assign res_ready_o  = ctx_q.busy;
    assign lane_state_o = ctx_q.lstate;
    assign shift_o      = ctx_q.shift;
    assign lock_o       = ctx_q.lock;
    assign done_o       = ctx_q.done;

    // R7: done lasts one cycle
    assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |=> !done_o);

    // R7: no words taken once the run has finished
    assert_ready_idle_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |-> !res_ready_o);

    // R7: beat counter never passes the run length while collecting
    assert_beat_bound_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        res_ready_o |-> (ctx_q.cnt < CNT_W'(BEATS)));

    // R7: outputs hold between runs
    assert_hold_idle_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (!res_ready_o && !start_i) |=>
            ($stable(lane_state_o) && $stable(shift_o) && $stable(lock_o)));

    // R5: a failed lane never reports lock
    assert_fail_unlocked_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (done_o && lane_state_o == LS_FAIL) |-> !lock_o);

endmodule

// File: tb/test_lane_shift_eval.sv
module test_lane_shift_eval;

    typedef struct packed {
        logic             mode;
        logic [1:0]       phase;
        logic [2:0]       st;
        logic [0:7][31:0] w;
        logic [2:0]       est;
        logic [5:0]       esh;
        logic             elock;
    } vec_t;

    localparam int NV = 16;

    // Expected values follow R1..R6; beat 0 is listed first.
    localparam vec_t VECS [NV] = '{
        // R2 R3 receive, all good: points 11,13,9,16,10,12,15,14 -> max 16
        '{1'b0, 2'd0, 3'd3, '{32'h0200000A, 32'h0200000C, 32'h02000008, 32'h0200000F,
                              32'h02000009, 32'h0200000B, 32'h0200000E, 32'h0200000D}, 3'd3, 6'd16, 1'b1},
        // R2 R3 transmit, all good: min delay 18 -> 17
        '{1'b1, 2'd0, 3'd3, '{32'h02000014, 32'h02000016, 32'h02000012, 32'h02000028,
                              32'h02000019, 32'h02000013, 32'h0200001E, 32'h02000015}, 3'd3, 6'd17, 1'b1},
        // R3 incomplete word on beat 2 -> state 1; later 30s must be ignored
        '{1'b0, 2'd0, 3'd3, '{32'h0200000A, 32'h0200000C, 32'h0000000A, 32'h0200001E,
                              32'h0200001E, 32'h0200001E, 32'h0200001E, 32'h0200001E}, 3'd1, 6'd13, 1'b0},
        // R3 transmit no edge on beat 0 -> state 4, nothing folded
        '{1'b1, 2'd0, 3'd3, '{32'h02000000, 32'h02000005, 32'h02000005, 32'h02000005,
                              32'h02000005, 32'h02000005, 32'h02000005, 32'h02000005}, 3'd4, 6'd0, 1'b0},
        // R4 receive all good -> stays 4, locked, max 10
        '{1'b0, 2'd1, 3'd4, '{32'h02000003, 32'h02000004, 32'h02000005, 32'h02000006,
                              32'h02000007, 32'h02000008, 32'h02000009, 32'h02000002}, 3'd4, 6'd10, 1'b1},
        // R4 transmit no edge on beat 3 -> state 2, min of first three = 7
        '{1'b1, 2'd1, 3'd4, '{32'h0200000A, 32'h02000008, 32'h0200000C, 32'h02000000,
                              32'h02000001, 32'h02000001, 32'h02000001, 32'h02000001}, 3'd2, 6'd7, 1'b0},
        // R4 incomplete on beat 0 -> state 2
        '{1'b0, 2'd1, 3'd4, '{32'h00000005, 32'h02000003, 32'h02000003, 32'h02000003,
                              32'h02000003, 32'h02000003, 32'h02000003, 32'h02000003}, 3'd2, 6'd0, 1'b0},
        // R5 receive, eight good -> lock, max 9
        '{1'b0, 2'd2, 3'd2, '{32'h02000001, 32'h02000002, 32'h02000003, 32'h02000004,
                              32'h02000005, 32'h02000006, 32'h02000007, 32'h02000008}, 3'd2, 6'd9, 1'b1},
        // R5 transmit, one no-edge word -> no lock, min 32
        '{1'b1, 2'd2, 3'd2, '{32'h02000021, 32'h02000022, 32'h02000023, 32'h02000024,
                              32'h02000025, 32'h02000000, 32'h02000026, 32'h02000027}, 3'd2, 6'd32, 1'b0},
        // R5 transmit incomplete on beat 6 -> state 1, beat 7 skipped
        '{1'b1, 2'd2, 3'd2, '{32'h0200000A, 32'h0200000B, 32'h0200000C, 32'h0200000D,
                              32'h0200000E, 32'h0200000F, 32'h00000010, 32'h02000002}, 3'd1, 6'd9, 1'b0},
        // R6 first phase, lane in state 2 -> ignored
        '{1'b0, 2'd0, 3'd2, '{32'h0200000A, 32'h0200000A, 32'h0200000A, 32'h0200000A,
                              32'h0200000A, 32'h0200000A, 32'h0200000A, 32'h0200000A}, 3'd2, 6'd0, 1'b0},
        // R6 phase 3 owns no state -> ignored
        '{1'b0, 2'd3, 3'd3, '{32'h0200000A, 32'h0200000A, 32'h0200000A, 32'h0200000A,
                              32'h0200000A, 32'h0200000A, 32'h0200000A, 32'h0200000A}, 3'd3, 6'd0, 1'b0},
        // R2 receive delay 30 -> point 31
        '{1'b0, 2'd0, 3'd3, '{32'h0200001E, 32'h0200001E, 32'h0200001E, 32'h0200001E,
                              32'h0200001E, 32'h0200001E, 32'h0200001E, 32'h0200001E}, 3'd3, 6'd31, 1'b1},
        // R1 receive drops bit 5: 0xEA -> delay 10 -> 11
        '{1'b0, 2'd0, 3'd3, '{32'h020000EA, 32'h020000EA, 32'h020000EA, 32'h020000EA,
                              32'h020000EA, 32'h020000EA, 32'h020000EA, 32'h020000EA}, 3'd3, 6'd11, 1'b1},
        // R1 transmit drops bit 6: 0x45 -> delay 5 -> 4
        '{1'b1, 2'd0, 3'd3, '{32'h02000045, 32'h02000045, 32'h02000045, 32'h02000045,
                              32'h02000045, 32'h02000045, 32'h02000045, 32'h02000045}, 3'd3, 6'd4, 1'b1},
        // R1 receive delay 31 is no edge -> state 4
        '{1'b0, 2'd0, 3'd3, '{32'h0200001F, 32'h0200000A, 32'h0200000A, 32'h0200000A,
                              32'h0200000A, 32'h0200000A, 32'h0200000A, 32'h0200000A}, 3'd4, 6'd0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        mode = 1'b0;
    logic [1:0]  phase = 2'd0;
    logic [2:0]  st_in = 3'd0;
    logic        valid = 1'b0;
    logic [31:0] word = '0;
    logic        ready;
    logic [2:0]  st_out;
    logic [5:0]  shift;
    logic        lock;
    logic        done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    lane_shift_eval i_lane_shift_eval (
        .clk_i       (clk),
        .rst_i       (rst),
        .start_i     (start),
        .mode_i      (mode),
        .phase_i     (phase),
        .lane_state_i(st_in),
        .res_valid_i (valid),
        .res_ready_o (ready),
        .res_word_i  (word),
        .lane_state_o(st_out),
        .shift_o     (shift),
        .lock_o      (lock),
        .done_o      (done)
    );

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic run_vec(input int i, input bit gap, input bit disturb);
        vec_t v = VECS[i];
        @(negedge clk);
        mode = v.mode; phase = v.phase; st_in = v.st; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk($sformatf("R7 ready at run open, vec %0d", i), ready, 1);
        for (int b = 0; b < 8; b++) begin
            if (gap) begin
                valid = 1'b0;
                @(negedge clk);
                chk($sformatf("R7 no early done, vec %0d", i), done, 0);
            end
            valid = 1'b1;
            word  = v.w[b];
            if (disturb && b == 3) begin
                start = 1'b1; phase = 2'd2; st_in = 3'd2; mode = ~v.mode;
            end
            @(negedge clk);
            start = 1'b0;
        end
        valid = 1'b0;
        chk($sformatf("R7 done after eighth beat, vec %0d", i), done, 1);
        chk($sformatf("R3 R4 R5 R6 lane state, vec %0d", i), st_out, v.est);
        chk($sformatf("R1 R2 shift, vec %0d", i), shift, v.esh);
        chk($sformatf("R3 R4 R5 lock, vec %0d", i), lock, v.elock);
        @(negedge clk);
        chk($sformatf("R7 done one cycle, vec %0d", i), done, 0);
        chk($sformatf("R7 ready low after run, vec %0d", i), ready, 0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 50000) begin
                errors++;
                $display("FAIL watchdog actual %0d expected below 50000", cycles);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8 reset state
        chk("R8 ready in reset", ready, 0);
        chk("R8 done in reset", done, 0);
        chk("R8 state in reset", st_out, 0);
        chk("R8 shift in reset", shift, 0);
        chk("R8 lock in reset", lock, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R7 ready idle", ready, 0);

        for (int i = 0; i < NV; i++) run_vec(i, 1'b0, 1'b0);

        // R7 beats with gaps in valid
        run_vec(7, 1'b1, 1'b0);
        // R7 start during a run is ignored
        run_vec(0, 1'b0, 1'b1);

        // R7 outputs hold while idle with valid toggling
        valid = 1'b1; word = 32'h02000001;
        repeat (4) @(negedge clk);
        valid = 1'b0;
        chk("R7 idle ignores valid, state", st_out, 3);
        chk("R7 idle ignores valid, shift", shift, 16);
        chk("R7 idle ignores valid, lock", lock, 1);

        // R8 reset in the middle of a run
        @(negedge clk);
        mode = 1'b0; phase = 2'd0; st_in = 3'd3; start = 1'b1;
        @(negedge clk);
        start = 1'b0; valid = 1'b1; word = 32'h0200000A;
        repeat (3) @(negedge clk);
        valid = 1'b0; rst = 1'b1;
        @(negedge clk);
        chk("R8 mid-run reset ready", ready, 0);
        chk("R8 mid-run reset state", st_out, 0);
        chk("R8 mid-run reset lock", lock, 0);
        rst = 1'b0;
        run_vec(4, 1'b0, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule